// File: doc/BRIEF.md
# Synchronous Block Preamble Detector

This block watches a serial bit stream and finds where a synchronous data block begins. A data block carries no start or stop bits, so the detector takes its byte alignment from the preamble alone. One bit is taken per clock in which the bit enable is high. Bits arrive most significant first.

A static mode input selects one of two framing schemes. In character mode the detector hunts for back-to-back sync characters at any bit offset. In flag mode it hunts for a run of ones closed by a single zero. Once it finds the preamble it raises a locked flag and cuts the following bits into bytes, each marked by a one-cycle valid strobe. A closing marker byte ends the block. The detector then drops lock, clears its bit history and starts hunting again. The mode input may change only while reset is held.

Top module: `sync_block_detector`

## Requirements
- R1: A synchronous reset, active high, clears the lock flag, the valid strobe and the bit history. A sync character received before reset does not pair with one received after it.
- R2: In character mode (`frame_mode` = 0) the detector locks when the 16 most recent bits equal two sync characters 0x16 0x16. This holds at any bit offset. A single sync character does not lock it.
- R3: In flag mode (`frame_mode` = 1) the detector locks when the 12 most recent bits equal 0xFFE, that is eleven ones and then a zero.
- R4: After lock, each run of 8 further enabled bits forms one byte, with the first bit received as bit 7. The first byte is the 8 bits that follow the last preamble bit. For a byte that is output, `byte_valid` is high for exactly one cycle, the cycle after the clock edge that takes in the byte's eighth bit, and `byte_out` holds the byte in that cycle.
- R5: In character mode, an aligned byte equal to 0x16 received after lock is treated as fill. It does not raise `byte_valid`, and lock is kept.
- R6: In character mode, an aligned byte equal to 0x9C ends the block. It is not output, lock drops with the edge that takes in its last bit, and the bit history is cleared.
- R7: In flag mode, an aligned byte equal to 0xFF ends the block, with the same effects as in R6. A byte equal to 0x16 is ordinary data in this mode.
- R8: In a cycle with `bit_en` low, the detector takes in no bit. The lock state does not change and `byte_valid` is low in the cycle that follows.
- R9: Each mode ignores the other mode's preamble. The pattern 0x1616 does not lock flag mode, and the pattern 0xFFE does not lock character mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_mode | input | 1 | 0 = character framing, 1 = flag framing; static |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data, most significant bit first |
| byte_out | output | 8 | Aligned received byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_out` |
| locked | output | 1 | High between preamble and closing marker |

## Verification
Directed streams place the preamble after a few bits of noise. They show whether lock happens at an odd bit offset, and whether the first byte falls on the boundary that follows the preamble rather than one shifted by the noise. Blocks containing embedded 0x16 bytes tell the two modes apart: the byte is dropped as fill in character mode and kept as data in flag mode. Feeding each mode's preamble to the other mode, and a lone sync character split by a reset, shows whether a near-miss pattern or stale history can cause a false lock. Random streams with random enable gaps and random block contents are compared bit by bit against a model in the bench. They cover stalls that fall in the middle of a byte.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   typedef enum logic {
      FRAME_CHAR = 1'b0,
      FRAME_FLAG = 1'b1
   } frame_mode_e;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } lock_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sbd_shifter.sv
module sbd_shifter #(
   parameter int unsigned SR_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            shift_en,
   input  logic            clr,
   input  logic            bit_in,
   output logic [SR_W-1:0] win,
   output logic [SR_W-1:0] sr_q
);
   if (SR_W < 2) begin : g_bad_w
      $error("sbd_shifter: SR_W must be at least 2");
   end

   // window as it will look once the current bit is taken in
   assign win = {sr_q[SR_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst || clr)    sr_q <= '0;
      else if (shift_en) sr_q <= win;
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      clr |=> (sr_q == '0)); // R6
   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
      (!shift_en && !clr) |=> $stable(sr_q)); // R8
endmodule

// File: rtl/sbd_matcher.sv
module sbd_matcher #(
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  SYN_CHAR  = 8'h16,
   parameter int unsigned SYN_COUNT = 2,
   parameter int unsigned FLAG_LEAD = 4,
   parameter int unsigned SR_W      = 16
) (
   input  logic            frame_mode,
   input  logic [SR_W-1:0] win,
   output logic            hit
);
   import sbd_pkg::*;

   localparam int unsigned SYN_W  = SYN_COUNT * DATA_W;
   localparam int unsigned FLAG_W = FLAG_LEAD + DATA_W;

   if (SYN_COUNT < 1) begin : g_bad_cnt
      $error("sbd_matcher: SYN_COUNT must be at least 1");
   end
   if (SR_W < SYN_W || SR_W < FLAG_W) begin : g_bad_sr
      $error("sbd_matcher: SR_W too small for preambles");
   end

   logic [SYN_W-1:0]  syn_pat;
   logic [FLAG_W-1:0] flag_pat;

   for (genvar g = 0; g < SYN_COUNT; g++) begin : g_syn_rep
      assign syn_pat[g*DATA_W +: DATA_W] = SYN_CHAR[DATA_W-1:0];
   end
   assign flag_pat = {{(FLAG_W-1){1'b1}}, 1'b0};

   logic syn_hit, flag_hit;
   assign syn_hit  = (win[SYN_W-1:0]  == syn_pat);
   assign flag_hit = (win[FLAG_W-1:0] == flag_pat);

   assign hit = (frame_mode_e'(frame_mode) == FRAME_FLAG) ? flag_hit : syn_hit;
endmodule

// File: rtl/sbd_framer.sv
module sbd_framer #(
   parameter int unsigned DATA_W   = 8,
   parameter logic [7:0]  SYN_CHAR = 8'h16,
   parameter logic [7:0]  END_CHAR = 8'h9C,
   parameter logic [7:0]  POST_CHAR = 8'hFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              frame_mode,
   input  logic              hit,
   input  logic [DATA_W-1:0] byte_in,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_valid,
   output logic              locked,
   output logic              clr_sr
);
   import sbd_pkg::*;

   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W < 4 || DATA_W > 8) begin : g_bad_dw
      $error("sbd_framer: DATA_W must lie in 4..8");
   end

   lock_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             is_flag, at_boundary, is_end, is_fill;

   assign is_flag     = (frame_mode_e'(frame_mode) == FRAME_FLAG);
   assign at_boundary = bit_en && (state_q == ST_LOCK) && (cnt_q == LAST);
   assign is_end      = is_flag ? (byte_in == POST_CHAR[DATA_W-1:0])
                                : (byte_in == END_CHAR[DATA_W-1:0]);
   assign is_fill     = !is_flag && (byte_in == SYN_CHAR[DATA_W-1:0]);
   assign clr_sr      = at_boundary && is_end;
   assign locked      = (state_q == ST_LOCK);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_HUNT;
         cnt_q      <= '0;
         byte_valid <= 1'b0;
         byte_out   <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (bit_en) begin
            unique case (state_q)
               ST_HUNT: begin
                  if (hit) begin
                     state_q <= ST_LOCK;
                     cnt_q   <= '0;
                  end
               end
               ST_LOCK: begin
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     if (is_end) begin
                        state_q <= ST_HUNT;
                     end else if (!is_fill) begin
                        byte_out   <= byte_in;
                        byte_valid <= 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      byte_valid |-> locked); // R4
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      byte_valid |=> !byte_valid); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> ($stable(locked) && !byte_valid)); // R8
   AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(bit_en)); // R2
   AST_NO_FILL_OUT: assert property (@(posedge clk) disable iff (rst)
      (byte_valid && !is_flag) |-> (byte_out != SYN_CHAR[DATA_W-1:0])); // R5
   AST_NO_END_OUT: assert property (@(posedge clk) disable iff (rst)
      (byte_valid && !is_flag) |-> (byte_out != END_CHAR[DATA_W-1:0])); // R6
   AST_NO_POST_OUT: assert property (@(posedge clk) disable iff (rst)
      (byte_valid && is_flag) |-> (byte_out != POST_CHAR[DATA_W-1:0])); // R7
   AST_END_DROPS: assert property (@(posedge clk) disable iff (rst)
      clr_sr |=> !locked); // R6
endmodule

// File: rtl/sync_block_detector.sv
module sync_block_detector #(
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  SYN_CHAR  = 8'h16,
   parameter int unsigned SYN_COUNT = 2,
   parameter int unsigned FLAG_LEAD = 4,
   parameter logic [7:0]  END_CHAR  = 8'h9C,
   parameter logic [7:0]  POST_CHAR = 8'hFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_mode,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_valid,
   output logic              locked
);
   import sbd_pkg::*;

   localparam int unsigned SR_W = max2(SYN_COUNT * DATA_W, FLAG_LEAD + DATA_W);

   logic [SR_W-1:0] win, sr_q;
   logic            hit, clr_sr;

   sbd_shifter #(.SR_W(SR_W)) u_shift (
      .clk(clk), .rst(rst), .shift_en(bit_en), .clr(clr_sr),
      .bit_in(bit_in), .win(win), .sr_q(sr_q)
   );

   sbd_matcher #(
      .DATA_W(DATA_W), .SYN_CHAR(SYN_CHAR), .SYN_COUNT(SYN_COUNT),
      .FLAG_LEAD(FLAG_LEAD), .SR_W(SR_W)
   ) u_match (
      .frame_mode(frame_mode), .win(win), .hit(hit)
   );

   sbd_framer #(
      .DATA_W(DATA_W), .SYN_CHAR(SYN_CHAR), .END_CHAR(END_CHAR),
      .POST_CHAR(POST_CHAR)
   ) u_frame (
      .clk(clk), .rst(rst), .bit_en(bit_en), .frame_mode(frame_mode),
      .hit(hit), .byte_in(win[DATA_W-1:0]), .byte_out(byte_out),
      .byte_valid(byte_valid), .locked(locked), .clr_sr(clr_sr)
   );

   AST_MODE_STATIC: assert property (@(posedge clk) disable iff (rst)
      $stable(frame_mode)); // R9
endmodule

// File: tb/sync_block_detector_tb_top.sv
`timescale 1ns/1ps
module sync_block_detector_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_mode = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] byte_out;
   logic       byte_valid, locked;

   int unsigned n_chk = 0, n_fail = 0;

   // bench reference state
   logic [15:0] m_sr;
   logic        m_lock;
   int          m_cnt;
   logic [7:0]  got_q[$];

   always #2 clk = ~clk;

   sync_block_detector dut_i (
      .clk(clk), .rst(rst), .frame_mode(frame_mode), .bit_en(bit_en),
      .bit_in(bit_in), .byte_out(byte_out), .byte_valid(byte_valid),
      .locked(locked)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst = 1'b1; bit_en = 1'b0; frame_mode = m;
      repeat (2) @(posedge clk);
      #1;
      m_sr = '0; m_lock = 1'b0; m_cnt = 0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one enabled bit; compare after the edge that takes it in
   task automatic send_bit(input logic b);
      logic [15:0] w;
      logic        ev;
      logic [7:0]  ed;
      @(negedge clk);
      bit_en = 1'b1; bit_in = b;
      @(posedge clk); #1;
      w = {m_sr[14:0], b};
      ev = 1'b0; ed = 8'h00;
      m_sr = w;
      if (!m_lock) begin
         if (frame_mode ? (w[11:0] == 12'hFFE) : (w == 16'h1616)) begin
            m_lock = 1'b1; m_cnt = 0;
         end
      end else begin
         m_cnt++;
         if (m_cnt == 8) begin
            m_cnt = 0;
            if (frame_mode ? (w[7:0] == 8'hFF) : (w[7:0] == 8'h9C)) begin
               m_lock = 1'b0; m_sr = '0;
            end else if (!(frame_mode == 1'b0 && w[7:0] == 8'h16)) begin
               ev = 1'b1; ed = w[7:0];
            end
         end
      end
      check(locked == m_lock, "R2/R3 locked", locked, m_lock);
      check(byte_valid == ev, "R4 byte_valid", byte_valid, ev);
      if (ev) check(byte_out == ed, "R4 byte_out", byte_out, ed);
      if (byte_valid) got_q.push_back(byte_out);
   endtask

   task automatic idle_cycle();
      logic l0;
      @(negedge clk);
      bit_en = 1'b0; bit_in = ~bit_in; l0 = locked;
      @(posedge clk); #1;
      check(locked == l0, "R8 lock held", locked, l0);
      check(byte_valid == 1'b0, "R8 no strobe", byte_valid, 0);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit gaps);
      for (int i = 7; i >= 0; i--) begin
         if (gaps && ($urandom_range(0, 3) == 0)) idle_cycle();
         send_bit(v[i]);
      end
   endtask

   task automatic expect_bytes(input string req, input logic [7:0] e[$]);
      check(got_q.size() == e.size(), req, got_q.size(), e.size());
      for (int i = 0; i < e.size() && i < got_q.size(); i++)
         check(got_q[i] == e[i], req, got_q[i], e[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] e[$];
      void'($urandom(32'd20240611));

      // R1: reset state
      do_reset(1'b0);
      #1;
      check(locked == 1'b0, "R1 locked after reset", locked, 0);
      check(byte_valid == 1'b0, "R1 valid after reset", byte_valid, 0);

      // R2/R4/R5/R6: char mode, 3 noise bits, SYN SYN, data with fill, end
      got_q.delete();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      send_byte(8'h16, 0);
      check(locked == 1'b0, "R2 one SYN no lock", locked, 0);
      send_byte(8'h16, 0);
      check(locked == 1'b1, "R2 two SYN lock", locked, 1);
      send_byte(8'hA5, 0); send_byte(8'h16, 0); send_byte(8'h3C, 0);
      check(locked == 1'b1, "R5 fill keeps lock", locked, 1);
      send_byte(8'h9C, 0);
      check(locked == 1'b0, "R6 end drops lock", locked, 0);
      e = '{8'hA5, 8'h3C};
      expect_bytes("R5 fill dropped / R4 order", e);

      // R6: history cleared after end; one SYN then no lock
      send_byte(8'h16, 0);
      check(locked == 1'b0, "R6 history cleared", locked, 0);

      // R1: stale SYN does not pair across reset
      do_reset(1'b0);
      send_byte(8'h16, 0);
      do_reset(1'b0);
      send_byte(8'h16, 0);
      check(locked == 1'b0, "R1 reset clears history", locked, 0);

      // R9: flag preamble ignored in char mode
      do_reset(1'b0);
      send_byte(8'hFF, 0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      check(locked == 1'b0, "R9 char ignores flag", locked, 0);

      // R3/R7: flag mode with 0x16 as data, gaps
      do_reset(1'b1);
      got_q.delete();
      send_byte(8'h16, 1); send_byte(8'h16, 1);
      check(locked == 1'b0, "R9 flag ignores SYN", locked, 0);
      for (int i = 0; i < 11; i++) send_bit(1'b1);
      send_bit(1'b0);
      check(locked == 1'b1, "R3 flag lock", locked, 1);
      send_byte(8'h16, 1); send_byte(8'h00, 1); send_byte(8'h9C, 1);
      send_byte(8'hFF, 1);
      check(locked == 1'b0, "R7 postamble drops lock", locked, 0);
      e = '{8'h16, 8'h00, 8'h9C};
      expect_bytes("R7 flag data kept", e);

      // R8: long stall mid-byte
      do_reset(1'b0);
      send_byte(8'h16, 0); send_byte(8'h16, 0);
      send_bit(1'b0); send_bit(1'b1);
      repeat (10) idle_cycle();
      check(locked == 1'b1, "R8 lock across stall", locked, 1);

      // random frames, checked bit by bit against the model
      for (int f = 0; f < 40; f++) begin
         logic md;
         int nd;
         logic [7:0] b;
         md = 1'($urandom_range(0, 1));
         do_reset(md);
         for (int k = $urandom_range(0, 7); k > 0; k--) send_bit(1'($urandom_range(0, 1)));
         if (!md) begin
            for (int k = $urandom_range(2, 4); k > 0; k--) send_byte(8'h16, 1);
         end else begin
            for (int k = $urandom_range(11, 20); k > 0; k--) send_bit(1'b1);
            send_bit(1'b0);
         end
         nd = $urandom_range(1, 6);
         for (int k = 0; k < nd; k++) begin
            b = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 4) == 0) b = 8'h16;
            if (b == 8'h9C || b == 8'hFF) b = 8'h5A;
            send_byte(b, 1);
         end
         send_byte(md ? 8'hFF : 8'h9C, 1);
         check(locked == 1'b0, "R6/R7 random end unlock", locked, 0);
      end

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule